// File: doc/BRIEF.md
# Interrupt Acceptance and Single-Step Trap Arbiter

This block decides, each time the instruction sequencer signals an instruction boundary, whether the core takes an interrupt and which source it serves. Four sources compete. The first is a vector of internal exception requests, which are level-sensitive. The second is a non-maskable external request, which is edge-triggered and held pending until it is served. The third is a level-sensitive maskable external request, which is gated by the interrupt-enable flag. The fourth is a single-step trap, which is raised while the trap flag is set.

The block holds the interrupt-enable and trap flags itself. The rest of the core writes them through a single write strobe. Taking any interrupt clears both flags. As a result, a handler is not preempted by maskable requests and is not single-stepped. The block's only results are a one-cycle take pulse and a 2-bit source code. Vector lookup, stacking and bus acknowledge cycles belong to other blocks.

Top module: `intr_accept`

## Requirements
- R1: After a synchronous active-low reset, `take_o` is 0, `type_o` is 0, both flags read 0 and no non-maskable request is pending.
- R2: When the enable flag is 1 and `intr_i` is high at a cycle with `bnd_i` high, `take_o` pulses in the next cycle with `type_o` = 2.
- R3: When the enable flag is 0, `intr_i` causes no take at any boundary.
- R4: A 0-to-1 transition on `nmi_i` is latched and served at a later boundary with `type_o` = 1, whatever the enable flag holds. Holding `nmi_i` high afterwards causes no second take.
- R5: Any set bit of `exc_i` at a boundary causes a take with `type_o` = 0, whatever the enable flag holds.
- R6: When the trap flag is 1 at a boundary, a single-step take with `type_o` = 3 occurs.
- R7: When several sources are ready at one boundary, the exception wins first, then the non-maskable request, then the maskable request, then the single-step trap. A non-maskable request that loses stays pending.
- R8: A take clears both flags in the cycle `take_o` is high. The clear overrides a flag write made in the same cycle. Without a take, a write loads `ie_d_i` and `tf_d_i`.
- R9: Without `bnd_i`, no take occurs, and a latched non-maskable request stays pending.
- R10: `type_o` is 0 in every cycle in which `take_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bnd_i | input | 1 | Instruction boundary strobe |
| exc_i | input | EXC_W | Internal exception requests, level |
| nmi_i | input | 1 | Non-maskable request, rising-edge |
| intr_i | input | 1 | Maskable request, level |
| flag_wr_i | input | 1 | Load both flags from the data inputs |
| ie_d_i | input | 1 | New interrupt-enable value |
| tf_d_i | input | 1 | New trap flag value |
| take_o | output | 1 | One-cycle take-interrupt pulse |
| type_o | output | 2 | Source code: 0 exception, 1 non-maskable, 2 maskable, 3 single-step |
| ie_o | output | 1 | Current interrupt-enable flag |
| tf_o | output | 1 | Current trap flag |

## Verification
A wrong flag state shows up at the ports in the next cycle. The flags are outputs, and a stale enable flag flips the take decision at the very next boundary. A lost or stuck non-maskable pending bit is only visible at a boundary: it either misses a take with code 1 or adds a spurious one. The bench therefore keeps a pending request idle across non-boundary cycles before serving it. A priority fault shows one cycle after a contested boundary as a wrong code, and it shows again at the following boundary through the source that was left pending.

// File: rtl/intr_pkg.sv
// Package: shared source codes for the interrupt acceptance block.
// Assumes: code order equals priority order (lowest code wins).
package intr_pkg;
    localparam int SRC_N  = 4;
    localparam int TYPE_W = $clog2(SRC_N);

    typedef enum logic [TYPE_W-1:0] {
        SRC_EXC  = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_MASK = 2'd2,
        SRC_STEP = 2'd3
    } src_e;
endpackage

// File: rtl/intr_nmi_latch.sv
// Module: rising-edge detector and pending latch for the non-maskable request.
// Assumes: nmi_i is already synchronous to clk; clr_i is high only in the
// cycle the arbiter serves this source. A new edge wins over a clear.
module intr_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic clr_i,
    output logic pend_o
);
    logic nmi_q;
    logic edge_seen;

    assign edge_seen = nmi_i & ~nmi_q;

    // Track the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= nmi_i;
    end

    // Set on an edge, drop when served.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_o <= 1'b0;
        else if (edge_seen)  pend_o <= 1'b1;
        else if (clr_i)      pend_o <= 1'b0;
    end

    a_r4_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_i && !nmi_q) |=> pend_o);
    a_r9_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);
    a_r4_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && $past(nmi_i) && nmi_i) |=> !pend_o);
endmodule

// File: rtl/intr_flags.sv
// Module: interrupt-enable and trap flag registers.
// Assumes: take_i is the arbiter's take decision for this cycle; it
// overrides any write made in the same cycle.
module intr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic ie_d_i,
    input  logic tf_d_i,
    input  logic take_i,
    output logic ie_o,
    output logic tf_o
);
    // Load, clear on take, or hold both flags.
    always_ff @(posedge clk) begin
        if (!rst_n || take_i) begin
            ie_o <= 1'b0;
            tf_o <= 1'b0;
        end else if (wr_i) begin
            ie_o <= ie_d_i;
            tf_o <= tf_d_i;
        end
    end

    a_r8_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (!ie_o && !tf_o));
    a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !take_i) |=> (ie_o == $past(ie_d_i) && tf_o == $past(tf_d_i)));
endmodule

// File: rtl/intr_prio.sv
// Module: fixed-priority selector; the lowest set request index wins.
// Assumes: request index equals the source code.
module intr_prio #(
    parameter int N = intr_pkg::SRC_N,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output logic [W-1:0] code_o
);
    // Scan from the lowest priority upward so the lowest index stays.
    always_comb begin
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) code_o = W'(i);
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/intr_accept.sv
// Module: top of the interrupt acceptance and single-step trap arbiter.
// At each boundary strobe it forms the request vector, picks the highest
// priority source and registers a one-cycle take pulse with its code.
// Assumes: all inputs synchronous to clk; exc_i bits are level requests.
module intr_accept
    import intr_pkg::*;
#(
    parameter int EXC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bnd_i,
    input  logic [EXC_W-1:0]  exc_i,
    input  logic              nmi_i,
    input  logic              intr_i,
    input  logic              flag_wr_i,
    input  logic              ie_d_i,
    input  logic              tf_d_i,
    output logic              take_o,
    output logic [TYPE_W-1:0] type_o,
    output logic              ie_o,
    output logic              tf_o
);
    logic [SRC_N-1:0]  req;
    logic              any_req;
    logic [TYPE_W-1:0] win_code;
    logic              take_now;
    logic              nmi_pend;
    logic              nmi_clr;

    intr_nmi_latch u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_i  (nmi_i),
        .clr_i  (nmi_clr),
        .pend_o (nmi_pend)
    );

    intr_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (flag_wr_i),
        .ie_d_i (ie_d_i),
        .tf_d_i (tf_d_i),
        .take_i (take_now),
        .ie_o   (ie_o),
        .tf_o   (tf_o)
    );

    // Request vector, indexed by source code; the enable flag gates only the maskable line.
    always_comb begin
        req           = '0;
        req[SRC_EXC]  = |exc_i;
        req[SRC_NMI]  = nmi_pend;
        req[SRC_MASK] = intr_i & ie_o;
        req[SRC_STEP] = tf_o;
    end

    intr_prio #(.N(SRC_N)) u_prio (
        .req_i  (req),
        .any_o  (any_req),
        .code_o (win_code)
    );

    assign take_now = bnd_i & any_req;
    assign nmi_clr  = take_now && (win_code == SRC_NMI);

    // Register the take pulse; the code is zero outside the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o <= 1'b0;
            type_o <= '0;
        end else begin
            take_o <= take_now;
            type_o <= take_now ? win_code : '0;
        end
    end

    a_r9_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_i |=> !take_o);
    a_r10_type_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (type_o == '0));
    a_r5_exc_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_i && (|exc_i)) |=> (take_o && type_o == SRC_EXC));
    a_r3_mask_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_i && !ie_o && !(|exc_i) && !nmi_pend && !tf_o) |=> !take_o);
    a_r6_step_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_i && tf_o) |=> take_o);
    a_r7_nmi_over_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_i && nmi_pend && !(|exc_i)) |=> (take_o && type_o == SRC_NMI));
endmodule

// File: tb/intr_accept_bench.sv
// Bench: a driver task applies one cycle of stimulus and pushes the expected
// {take, type, ie, tf} from a requirement-level model; a monitor pops and compares.
module intr_accept_bench;
    import intr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int EXC_W      = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bnd_i = 1'b0;
    logic [EXC_W-1:0]  exc_i = '0;
    logic              nmi_i = 1'b0;
    logic              intr_i = 1'b0;
    logic              flag_wr_i = 1'b0;
    logic              ie_d_i = 1'b0;
    logic              tf_d_i = 1'b0;
    logic              take_o;
    logic [TYPE_W-1:0] type_o;
    logic              ie_o;
    logic              tf_o;

    intr_accept #(.EXC_W(EXC_W)) u_intr_accept (
        .clk(clk), .rst_n(rst_n), .bnd_i(bnd_i), .exc_i(exc_i),
        .nmi_i(nmi_i), .intr_i(intr_i), .flag_wr_i(flag_wr_i),
        .ie_d_i(ie_d_i), .tf_d_i(tf_d_i), .take_o(take_o),
        .type_o(type_o), .ie_o(ie_o), .tf_o(tf_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [4:0] q_exp[$];
    string      q_tag[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Requirement-level model state.
    logic m_ie = 1'b0, m_tf = 1'b0, m_pend = 1'b0, m_prev = 1'b0;

    task automatic cyc(input string tag, input logic bnd, input logic [EXC_W-1:0] exc,
                       input logic nmi, input logic intr, input logic wr,
                       input logic iev, input logic tfv);
        logic tk;
        logic [1:0] ty;
        @(negedge clk);
        bnd_i = bnd; exc_i = exc; nmi_i = nmi; intr_i = intr;
        flag_wr_i = wr; ie_d_i = iev; tf_d_i = tfv;
        tk = 1'b1; ty = 2'd0;
        if (!bnd)                 tk = 1'b0;
        else if (exc != '0)       ty = 2'd0;
        else if (m_pend)          ty = 2'd1;
        else if (intr && m_ie)    ty = 2'd2;
        else if (m_tf)            ty = 2'd3;
        else                      tk = 1'b0;
        if (!tk) ty = 2'd0;
        m_pend = (m_pend && !(tk && ty == 2'd1)) || (nmi && !m_prev);
        m_prev = nmi;
        if (tk)      begin m_ie = 1'b0; m_tf = 1'b0; end
        else if (wr) begin m_ie = iev;  m_tf = tfv;  end
        q_exp.push_back({tk, ty, m_ie, m_tf});
        q_tag.push_back(tag);
    endtask

    // Monitor: compare one expected item per cycle, away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q_exp.size() > 0) begin
                logic [4:0] e, a;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                a = {take_o, type_o, ie_o, tf_o};
                n_chk++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: {take,type,ie,tf} actual=%b expected=%b", t, a, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, idle.
        cyc("R1 reset", 0, '0, 0, 0, 0, 0, 0);
        cyc("R10 idle type", 0, '0, 0, 1, 0, 0, 0);
        // R3: maskable ignored while enable is clear.
        cyc("R3 masked", 1, '0, 0, 1, 0, 0, 0);
        cyc("R3 masked again", 1, '0, 0, 1, 0, 0, 0);
        // R2: set enable, then take maskable; R8 clears enable.
        cyc("R8 write ie", 0, '0, 0, 1, 1, 1, 0);
        cyc("R2 maskable taken", 1, '0, 0, 1, 0, 0, 0);
        cyc("R3 after clear", 1, '0, 0, 1, 0, 0, 0);
        // R4/R9: non-maskable edge held across non-boundary cycles.
        cyc("R4 nmi edge", 0, '0, 1, 0, 0, 0, 0);
        cyc("R9 pend held", 0, '0, 1, 0, 0, 0, 0);
        cyc("R4 nmi taken", 1, '0, 1, 0, 0, 0, 0);
        cyc("R4 no retrigger", 1, '0, 1, 0, 0, 0, 0);
        cyc("R4 line low", 1, '0, 0, 0, 0, 0, 0);
        // R5: exceptions ignore the enable flag.
        cyc("R5 exc bit0", 1, 4'b0001, 0, 0, 0, 0, 0);
        cyc("R5 exc bit3", 1, 4'b1000, 0, 1, 0, 0, 0);
        // R6: single-step trap after each instruction while set.
        cyc("R6 write tf", 0, '0, 0, 0, 1, 0, 1);
        cyc("R6 step", 1, '0, 0, 0, 0, 0, 0);
        cyc("R6 write tf again", 0, '0, 0, 0, 1, 0, 1);
        cyc("R9 no boundary", 0, '0, 0, 0, 0, 0, 0);
        cyc("R6 step again", 1, '0, 0, 0, 0, 0, 0);
        cyc("R6 cleared", 1, '0, 0, 0, 0, 0, 0);
        // R7: all four ready at once, served in priority order.
        cyc("R7 setup", 0, '0, 1, 1, 1, 1, 1);
        cyc("R7 exc first", 1, 4'b0100, 1, 1, 0, 0, 0);
        cyc("R7 reload", 0, '0, 0, 1, 1, 1, 1);
        cyc("R7 nmi second", 1, '0, 0, 1, 0, 0, 0);
        cyc("R7 reload", 0, '0, 0, 1, 1, 1, 1);
        cyc("R7 mask third", 1, '0, 0, 1, 0, 0, 0);
        cyc("R7 reload tf", 0, '0, 0, 1, 1, 0, 1);
        cyc("R7 step last", 1, '0, 0, 1, 0, 0, 0);
        // R8: take overrides same-cycle write.
        cyc("R8 take beats write", 1, 4'b0010, 0, 0, 1, 1, 1);
        cyc("R8 write loads", 0, '0, 0, 0, 1, 1, 0);
        cyc("R2 maskable", 1, '0, 0, 1, 0, 0, 0);
        cyc("R10 idle", 0, '0, 0, 0, 0, 0, 0);
        while (q_exp.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule